// File: doc/BRIEF.md
# Receive Byte FIFO with Status Tags and Interrupt Logic

This block sits between a bit-level packet deframer and a processor read port. The deframer pushes each recovered byte with a 3-bit status code that describes the byte. The processor pops bytes one at a time. The head entry is always shown on the read outputs, with its data and status. An empty flag and a sticky overrun flag complete the read side.

The capacity is 128 entries. A push into a full FIFO is not simply dropped. It counts as an overrun: the whole FIFO is flushed and the overrun flag is raised.

Interrupts come from five sources. Three are event strobes from the deframer: link-opening flag, closing flag and abort. The other two are the fill level rising above a programmable 7-bit threshold, and an overrun. Any of them sets a sticky interrupt status bit. When the interrupt enable is high, that bit drives an active-low interrupt pin. A software terminate, or a low enable, empties the FIFO and clears all pending state.

Top module: `pkt_status_fifo`

## Requirements
- R1: After reset the outputs are as follows: `empty_o`=1, `ovr_o`=0, `int_stat_o`=0, `int_no`=1, `rd_data_o`=0 and `rd_stat_o`=3'b111.
- R2: Bytes are read in write order, each with its own 3-bit status. `rd_data_o`/`rd_stat_o` show the head entry. A high `rd_en_i` at a clock edge pops that entry. Pointers wrap around with no loss.
- R3: `empty_o` is 1 exactly when the FIFO holds no byte. While it is empty, `rd_data_o` is 0 and `rd_stat_o` is the reserved code 3'b111. A read strobe while empty changes nothing.
- R4: The FIFO holds 128 bytes written without any read, and all 128 are returned intact.
- R5: A write to a full FIFO with no read in the same cycle flushes the FIFO, discards the written byte and sets `ovr_o`. A write and a read together at full cause no overrun.
- R6: `ovr_o` stays 1 until a `stat_rd_i` strobe clears it, even after later writes refill the FIFO.
- R7: When the fill level goes from at most `thr_i` to above `thr_i`, `int_stat_o` sets one clock after the edge that changed the level.
- R8: A one-cycle pulse on `ev_open_i`, `ev_close_i` or `ev_abort_i` sets `int_stat_o` at that edge. An overrun also sets it at that edge.
- R9: `int_stat_o` is sticky. It is cleared by `stat_rd_i` or `int_clr_i`. A source that fires in the same cycle as a clear wins, and the bit stays set.
- R10: `int_no` is 0 exactly when `int_stat_o`=1 and `int_en_i`=1.
- R11: A `term_i` pulse, or any cycle with `en_i`=0, empties the FIFO and clears `ovr_o` and `int_stat_o`. Writes and events are ignored while `en_i`=0 or `term_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low holds the FIFO flushed |
| term_i | input | 1 | Terminate strobe; flushes and clears |
| wr_en_i | input | 1 | Push strobe from the deframer |
| wr_data_i | input | 8 | Byte to push |
| wr_stat_i | input | 3 | Status code of the pushed byte |
| rd_en_i | input | 1 | Pop strobe |
| rd_data_o | output | 8 | Head byte (0 when empty) |
| rd_stat_o | output | 3 | Head status (3'b111 when empty) |
| empty_o | output | 1 | FIFO holds no byte |
| ovr_o | output | 1 | Sticky overrun flag |
| thr_i | input | 7 | Fill threshold |
| ev_open_i | input | 1 | Opening-flag event |
| ev_close_i | input | 1 | Closing-flag event |
| ev_abort_i | input | 1 | Abort event |
| stat_rd_i | input | 1 | Status read strobe; clears overrun and interrupt status |
| int_clr_i | input | 1 | Write-one-to-clear of interrupt status |
| int_en_i | input | 1 | Interrupt pin enable |
| int_stat_o | output | 1 | Sticky interrupt status |
| int_no | output | 1 | Active-low interrupt pin |

## Verification
The first pattern is a straight fill of all 128 entries followed by a full drain, using arithmetic data and status patterns. It separates lost or duplicated entries from ordering faults. The second pattern mixes pushes, pops and simultaneous push-and-pop over several pointer wraps and at the full boundary, and compares against an arithmetic queue model. This tells a real overrun apart from a legal full-level exchange. A threshold sweep from 0 to 127 checks that the interrupt fires exactly one cycle after the level first exceeds the setting and never before. Separate runs of events, clears, overrun and flush show which sources set the sticky bits, which strobes clear them, and that a set wins over a clear in the same cycle.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 3;
  localparam logic [STAT_W-1:0] STAT_EMPTY = 3'b111;

  // interrupt source indices
  localparam int SRC_OPEN  = 0;
  localparam int SRC_CLOSE = 1;
  localparam int SRC_ABORT = 2;
  localparam int SRC_THR   = 3;
  localparam int SRC_OVR   = 4;
  localparam int NSRC      = 5;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [STAT_W-1:0] stat;
  } entry_t;
endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store
  import pkt_fifo_pkg::*;
#(
  parameter  int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  entry_t           wr_ent_i,
  output entry_t           head_o,
  output logic [CNT_W-1:0] fill_o,
  output logic             ovr_ev_o
);
  entry_t           mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, do_push, do_pop, overrun;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty & ~flush_i;
  // a simultaneous pop frees the slot, so a full exchange is legal
  assign overrun = push_i & full & ~do_pop & ~flush_i;
  assign do_push = push_i & (~full | do_pop) & ~flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wr_ent_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i || overrun) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o   = mem_q[rd_ptr_q];
  assign fill_o   = cnt_q;
  assign ovr_ev_o = overrun;
endmodule

// File: rtl/pkt_fifo_thr.sv
module pkt_fifo_thr #(
  parameter int CNT_W = 8,
  parameter int THR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             rise_o
);
  logic hit, hit_q;

  assign hit = (fill_i > CNT_W'(thr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit & ~clr_i;
  end

  assign rise_o = hit & ~hit_q & ~clr_i;
endmodule

// File: rtl/pkt_fifo_irq.sv
module pkt_fifo_irq #(
  parameter int NSRC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_all_i,
  input  logic            ack_i,
  input  logic [NSRC-1:0] src_i,
  input  logic            int_en_i,
  output logic            int_stat_o,
  output logic            int_no
);
  logic stat_q;

  // set beats acknowledge; flush beats both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_q <= 1'b0;
    else if (clr_all_i) stat_q <= 1'b0;
    else if (|src_i)    stat_q <= 1'b1;
    else if (ack_i)     stat_q <= 1'b0;
  end

  assign int_stat_o = stat_q;
  assign int_no     = ~(stat_q & int_en_i);
endmodule

// File: rtl/pkt_status_fifo.sv
module pkt_status_fifo
  import pkt_fifo_pkg::*;
#(
  parameter  int DEPTH = 128,
  parameter  int THR_W = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              term_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [STAT_W-1:0] wr_stat_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] rd_stat_o,
  output logic              empty_o,
  output logic              ovr_o,
  input  logic [THR_W-1:0]  thr_i,
  input  logic              ev_open_i,
  input  logic              ev_close_i,
  input  logic              ev_abort_i,
  input  logic              stat_rd_i,
  input  logic              int_clr_i,
  input  logic              int_en_i,
  output logic              int_stat_o,
  output logic              int_no
);
  logic             clr_all, ovr_ev, thr_rise, ovr_q;
  logic [CNT_W-1:0] fill;
  logic [NSRC-1:0]  src;
  entry_t           wr_ent, head;

  assign clr_all = term_i | ~en_i;
  assign wr_ent  = '{data: wr_data_i, stat: wr_stat_i};

  pkt_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (clr_all),
    .push_i   (wr_en_i),
    .pop_i    (rd_en_i),
    .wr_ent_i (wr_ent),
    .head_o   (head),
    .fill_o   (fill),
    .ovr_ev_o (ovr_ev)
  );

  pkt_fifo_thr #(.CNT_W(CNT_W), .THR_W(THR_W)) u_thr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_all),
    .fill_i (fill),
    .thr_i  (thr_i),
    .rise_o (thr_rise)
  );

  always_comb begin
    src            = '0;
    src[SRC_OPEN]  = ev_open_i;
    src[SRC_CLOSE] = ev_close_i;
    src[SRC_ABORT] = ev_abort_i;
    src[SRC_THR]   = thr_rise;
    src[SRC_OVR]   = ovr_ev;
  end

  pkt_fifo_irq #(.NSRC(NSRC)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_all_i  (clr_all),
    .ack_i      (stat_rd_i | int_clr_i),
    .src_i      (src),
    .int_en_i   (int_en_i),
    .int_stat_o (int_stat_o),
    .int_no     (int_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (clr_all)   ovr_q <= 1'b0;
    else if (ovr_ev)    ovr_q <= 1'b1;
    else if (stat_rd_i) ovr_q <= 1'b0;
  end

  assign empty_o   = (fill == '0);
  assign rd_data_o = empty_o ? '0 : head.data;
  assign rd_stat_o = empty_o ? STAT_EMPTY : head.stat;
  assign ovr_o     = ovr_q;
endmodule

// File: rtl/pkt_status_fifo_chk.sv
module pkt_status_fifo_chk #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             term_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic             empty_o,
  input logic             ovr_o,
  input logic [2:0]       rd_stat_o,
  input logic [7:0]       rd_data_o,
  input logic             ev_abort_i,
  input logic             stat_rd_i,
  input logic             int_clr_i,
  input logic             int_en_i,
  input logic             int_stat_o,
  input logic             int_no,
  input logic [CNT_W-1:0] fill
);
  a_r3_empty_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_stat_o == 3'b111 && rd_data_o == 8'h00));

  a_r3_empty_read_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i && !wr_en_i) |=> empty_o);

  a_r5_overrun_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !term_i && wr_en_i && !rd_en_i && fill == CNT_W'(DEPTH))
      |=> (empty_o && ovr_o && int_stat_o));

  a_r6_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !stat_rd_i && en_i && !term_i) |=> ovr_o);

  a_r8_abort_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !term_i && ev_abort_i) |=> int_stat_o);

  a_r9_int_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_stat_o && !stat_rd_i && !int_clr_i && en_i && !term_i) |=> int_stat_o);

  a_r10_pin_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_i |-> int_no);

  a_r11_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i || !en_i) |=> (empty_o && !ovr_o && !int_stat_o));
endmodule

bind pkt_status_fifo pkt_status_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .term_i     (term_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .empty_o    (empty_o),
  .ovr_o      (ovr_o),
  .rd_stat_o  (rd_stat_o),
  .rd_data_o  (rd_data_o),
  .ev_abort_i (ev_abort_i),
  .stat_rd_i  (stat_rd_i),
  .int_clr_i  (int_clr_i),
  .int_en_i   (int_en_i),
  .int_stat_o (int_stat_o),
  .int_no     (int_no),
  .fill       (fill)
);

// File: tb/pkt_status_fifo_test.sv
module pkt_status_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 0, rst_n = 0;
  logic en = 0, term = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_stat = 0;
  logic [6:0] thr = 7'd127;
  logic ev_open = 0, ev_close = 0, ev_abort = 0, stat_rd = 0, int_clr = 0, int_en = 0;
  logic [7:0] rd_data;
  logic [2:0] rd_stat;
  logic empty, ovr, int_stat, int_n;

  int checks = 0, fails = 0;

  // arithmetic queue model
  logic [7:0] mq_d [DEPTH];
  logic [2:0] mq_s [DEPTH];
  int mh = 0, mt = 0, mc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_status_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .term_i(term),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_stat_i(wr_stat),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_stat_o(rd_stat),
    .empty_o(empty), .ovr_o(ovr), .thr_i(thr),
    .ev_open_i(ev_open), .ev_close_i(ev_close), .ev_abort_i(ev_abort),
    .stat_rd_i(stat_rd), .int_clr_i(int_clr), .int_en_i(int_en),
    .int_stat_o(int_stat), .int_no(int_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] s);
    wr_en = 1; wr_data = d; wr_stat = s;
    step();
    wr_en = 0;
  endtask

  task automatic pop();
    rd_en = 1;
    step();
    rd_en = 0;
  endtask

  task automatic sread();
    stat_rd = 1;
    step();
    stat_rd = 0;
  endtask

  task automatic flush();
    term = 1;
    step();
    term = 0;
    mh = 0; mt = 0; mc = 0;
  endtask

  task automatic model_push(input logic [7:0] d, input logic [2:0] s);
    mq_d[mt] = d; mq_s[mt] = s; mt = (mt + 1) % DEPTH; mc++;
  endtask

  task automatic check_head(input string req);
    chk(empty == (mc == 0), req, empty, mc == 0);
    if (mc > 0) begin
      chk(rd_data == mq_d[mh], req, rd_data, mq_d[mh]);
      chk(rd_stat == mq_s[mh], req, rd_stat, mq_s[mh]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(empty == 1, "R1", empty, 1);
    chk(ovr == 0, "R1", ovr, 0);
    chk(int_stat == 0, "R1", int_stat, 0);
    chk(int_n == 1, "R1", int_n, 1);
    rst_n = 1; en = 1;
    step();
    chk(rd_stat == 3'b111 && rd_data == 0, "R1", rd_stat, 7);

    // R3 read on empty changes nothing
    pop();
    chk(empty == 1, "R3", empty, 1);
    chk(rd_stat == 3'b111, "R3", rd_stat, 7);
    chk(rd_data == 8'h00, "R3", rd_data, 0);
    push(8'h5a, 3'd2);
    chk(empty == 0, "R3", empty, 0);
    chk(rd_data == 8'h5a && rd_stat == 3'd2, "R3", rd_data, 8'h5a);
    pop();
    chk(empty == 1, "R3", empty, 1);

    // R4 fill to capacity then drain, R2 order
    sread();
    for (int i = 0; i < DEPTH; i++) begin
      push(8'((i * 37 + 11) & 255), 3'(i % 7));
      model_push(8'((i * 37 + 11) & 255), 3'(i % 7));
    end
    chk(ovr == 0, "R4", ovr, 0);
    for (int i = 0; i < DEPTH; i++) begin
      check_head("R4");
      pop();
      mh = (mh + 1) % DEPTH; mc--;
    end
    chk(empty == 1, "R4", empty, 1);

    // R2 mixed traffic with wraps and full-level exchanges
    for (int k = 0; k < 700; k++) begin
      int op;
      logic [7:0] d;
      logic [2:0] s;
      op = k % 5;
      d = 8'((k * 13 + 5) & 255);
      s = 3'(k % 7);
      check_head("R2");
      if (op <= 2 && mc < DEPTH) begin
        push(d, s); model_push(d, s);
      end else if (op == 3 && mc > 0) begin
        pop(); mh = (mh + 1) % DEPTH; mc--;
      end else if (mc > 0) begin
        wr_en = 1; wr_data = d; wr_stat = s; rd_en = 1;
        step();
        wr_en = 0; rd_en = 0;
        mh = (mh + 1) % DEPTH; mc--;
        model_push(d, s);
      end
    end
    chk(ovr == 0, "R5", ovr, 0);
    while (mc > 0) begin
      check_head("R2");
      pop(); mh = (mh + 1) % DEPTH; mc--;
    end
    chk(empty == 1, "R2", empty, 1);

    // R5 overrun flushes, R6 sticky overrun
    flush();
    for (int i = 0; i < DEPTH; i++) push(8'(i), 3'd1);
    chk(empty == 0 && ovr == 0, "R5", ovr, 0);
    push(8'hee, 3'd4);
    chk(empty == 1, "R5", empty, 1);
    chk(ovr == 1, "R5", ovr, 1);
    chk(int_stat == 1, "R8", int_stat, 1);
    for (int i = 0; i < 5; i++) push(8'(8'h40 + i), 3'd3);
    chk(ovr == 1, "R6", ovr, 1);
    chk(rd_data == 8'h40 && rd_stat == 3'd3, "R5", rd_data, 8'h40);
    sread();
    chk(ovr == 0, "R6", ovr, 0);
    chk(int_stat == 0, "R9", int_stat, 0);

    // R7 threshold sweep
    for (int t = 0; t < DEPTH; t++) begin
      flush();
      thr = 7'(t);
      sread();
      for (int j = 0; j < t; j++) begin
        push(8'(j), 3'd0);
        step();
        chk(int_stat == 0, "R7", int_stat, 0);
      end
      push(8'hff, 3'd0);
      chk(int_stat == 0, "R7", int_stat, 0);
      step();
      chk(int_stat == 1, "R7", int_stat, 1);
    end

    // R8 events, R9 clears, R10 pin
    flush();
    thr = 7'd127;
    for (int e = 0; e < 3; e++) begin
      ev_open = (e == 0); ev_close = (e == 1); ev_abort = (e == 2);
      step();
      ev_open = 0; ev_close = 0; ev_abort = 0;
      chk(int_stat == 1, "R8", int_stat, 1);
      step();
      chk(int_stat == 1, "R9", int_stat, 1);
      int_clr = 1; step(); int_clr = 0;
      chk(int_stat == 0, "R9", int_stat, 0);
    end
    ev_close = 1; int_clr = 1; step(); ev_close = 0; int_clr = 0;
    chk(int_stat == 1, "R9", int_stat, 1);
    int_en = 0; step();
    chk(int_n == 1, "R10", int_n, 1);
    int_en = 1; step();
    chk(int_n == 0, "R10", int_n, 0);
    sread();
    chk(int_n == 1, "R10", int_n, 1);

    // R11 terminate and enable
    for (int i = 0; i < DEPTH + 1; i++) push(8'(i), 3'd5);
    chk(ovr == 1 && int_stat == 1, "R11", ovr, 1);
    push(8'h11, 3'd1);
    term = 1; step(); term = 0;
    chk(empty == 1 && ovr == 0 && int_stat == 0, "R11", empty, 1);
    push(8'h22, 3'd1);
    en = 0; step();
    chk(empty == 1, "R11", empty, 1);
    push(8'h33, 3'd2);
    ev_abort = 1; step(); ev_abort = 0;
    chk(empty == 1 && int_stat == 0, "R11", int_stat, 0);
    en = 1; step();
    chk(empty == 1 && int_n == 1, "R11", empty, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule